// File: doc/BRIEF.md
# Instruction Packet Boundary Parser

This block sits behind an instruction fetch path and groups a stream of 32-bit instruction words into execution packets. One word may be offered per cycle, qualified by `in_valid`. Each word carries a 2-bit grouping code in bits [15:14]. The block reads that code and reports, for every accepted word, its slot in the packet and whether the word closes the packet. It also reports whether the word is a paired-operation (duplex) container. When a packet closes, the block reports how many words the packet held. It also reports whether the packet is the closing packet of hardware loop 0, of loop 1, or of both. These loop markers are not carried in a field of their own. They are taken from the codes of the packet's first and second words.

A word that closes a packet carries code 11 or code 00. Code 00 also marks the duplex form. Codes 01 and 10 mean that more words follow. A packet may hold at most four words. If a fourth word still carries 01 or 10, the block flags an illegal opcode and treats the following word as the start of a fresh packet. All results are registered and appear one cycle after the word is accepted.

The control is a four-state machine, one state for each slot:
- `S_W0` waits for the first word of a packet.
- `S_W1`, `S_W2` and `S_W3` wait for the second, third and fourth words.

The transitions are:
- Advance: an accepted word with code 01 or 10 moves `S_Wn` to `S_Wn+1` (n < 3).
- Close: an accepted word with code 11 or 00 returns any state to `S_W0`.
- Overrun: an accepted word with code 01 or 10 in `S_W3` returns to `S_W0` and raises the illegal flag.
- Hold: a cycle without `in_valid` keeps the current state.

Top module: `pkt_boundary_parser`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is 0 and the parser waits for the first word of a packet.
- R2: `out_valid` is `in_valid` delayed by one cycle. `out_pos` gives the slot index (0 to 3) of that word within its packet.
- R3: A word whose bits [15:14] equal 11 is reported with `out_last`=1. The next accepted word has `out_pos`=0.
- R4: A word whose bits [15:14] equal 00 is reported with `out_duplex`=1 and `out_last`=1. The next accepted word has `out_pos`=0.
- R5: A word whose bits [15:14] equal 01 or 10 is reported with `out_last`=0 and `out_duplex`=0.
- R6: `out_count` equals the number of words in the packet (1 to 4) in the cycle that reports the closing word. It is 0 in every other cycle.
- R7: `out_loop0` is 1 in the closing word's cycle when the packet's first word had code 10. Otherwise it is 0.
- R8: `out_loop1` is 1 in the closing word's cycle when the packet's second word had code 10. It can be set together with `out_loop0`. A one-word packet never sets it.
- R9: A fourth word with code 01 or 10 is reported with `out_illegal`=1, `out_last`=0, `out_count`=0 and both loop flags 0. The next accepted word starts a new packet at `out_pos`=0.
- R10: Cycles with `in_valid`=0 do not change the slot position or the loop markers. In the following cycle they leave `out_valid`, `out_pos`, `out_last`, `out_duplex`, `out_count`, the loop flags and `out_illegal` at 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on `in_word` is offered this cycle |
| in_word | input | 32 | Instruction word, grouping code in [15:14] |
| out_valid | output | 1 | A word was accepted in the previous cycle |
| out_pos | output | 2 | Slot index of that word in its packet |
| out_last | output | 1 | That word closes its packet |
| out_duplex | output | 1 | That word is a duplex container |
| out_count | output | 3 | Packet word count when closing, else 0 |
| out_loop0 | output | 1 | Closing packet ends hardware loop 0 |
| out_loop1 | output | 1 | Closing packet ends hardware loop 1 |
| out_illegal | output | 1 | Four words passed without a closing code |

## Verification
Every result belongs to the word accepted at a given rising edge and is visible from that edge until the next one. This includes slot, last, duplex, count, loop flags and illegal. The bench drives a word on a falling edge. On the following falling edge it compares all outputs against a queue-based model of the packet built from the words it sent, then drives the next word. Idle cycles inside packets show that the one-cycle offset holds against the accepted word and not against wall-clock cycles. The overrun and resync cases check the cycle of the fourth word and the cycle of the word after it.

// File: rtl/pkt_parse_pkg.sv
package pkt_parse_pkg;

    localparam int MAX_PKT_WORDS = 4;
    localparam int SLOT_W        = $clog2(MAX_PKT_WORDS);
    localparam int COUNT_W       = $clog2(MAX_PKT_WORDS + 1);

    typedef enum logic [1:0] {
        PC_PAIRED = 2'b00,
        PC_MORE   = 2'b01,
        PC_MARK   = 2'b10,
        PC_CLOSE  = 2'b11
    } grp_code_t;

    typedef enum logic [SLOT_W-1:0] {
        S_W0 = 2'd0,
        S_W1 = 2'd1,
        S_W2 = 2'd2,
        S_W3 = 2'd3
    } slot_state_t;

endpackage

// File: rtl/grp_code_decode.sv
module grp_code_decode
    import pkt_parse_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int CODE_LSB = 14
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              closes_o,
    output logic              paired_o,
    output logic              mark_o
);

    grp_code_t code;

    always_comb begin
        code     = grp_code_t'(word_i[CODE_LSB +: 2]);
        closes_o = 1'b0;
        paired_o = 1'b0;
        mark_o   = 1'b0;
        unique case (code)
            PC_PAIRED: begin
                closes_o = 1'b1;
                paired_o = 1'b1;
            end
            PC_CLOSE:  closes_o = 1'b1;
            PC_MARK:   mark_o   = 1'b1;
            PC_MORE:   ;
        endcase
    end

endmodule

// File: rtl/slot_fsm.sv
module slot_fsm
    import pkt_parse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              closes_i,
    output logic [SLOT_W-1:0] pos_o,
    output logic              close_o,
    output logic              overrun_o
);

    slot_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_W0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        close_o   = 1'b0;
        overrun_o = 1'b0;
        if (step_i) begin
            if (closes_i) begin
                close_o = 1'b1;
                state_d = S_W0;
            end else begin
                unique case (state_q)
                    S_W0: state_d = S_W1;
                    S_W1: state_d = S_W2;
                    S_W2: state_d = S_W3;
                    S_W3: begin
                        overrun_o = 1'b1;
                        state_d   = S_W0;
                    end
                endcase
            end
        end
    end

    assign pos_o = state_q;

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q));
    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !closes_i && state_q != S_W3) |=> pos_o == $past(pos_o) + 2'd1);
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && closes_i) |=> state_q == S_W0);
    p_resync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> state_q == S_W0);

endmodule

// File: rtl/loop_mark_track.sv
module loop_mark_track
    import pkt_parse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [SLOT_W-1:0] pos_i,
    input  logic              mark_i,
    input  logic              end_i,
    output logic              loop0_o,
    output logic              loop1_o
);

    logic first_mark_q, second_mark_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_mark_q  <= 1'b0;
            second_mark_q <= 1'b0;
        end else if (end_i) begin
            first_mark_q  <= 1'b0;
            second_mark_q <= 1'b0;
        end else if (step_i && mark_i) begin
            if (pos_i == SLOT_W'(0)) first_mark_q  <= 1'b1;
            if (pos_i == SLOT_W'(1)) second_mark_q <= 1'b1;
        end
    end

    assign loop0_o = first_mark_q;
    assign loop1_o = second_mark_q;

    p_loop1_after_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
        second_mark_q |-> pos_i >= SLOT_W'(2));

endmodule

// File: rtl/pkt_boundary_parser.sv
module pkt_boundary_parser
    import pkt_parse_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int CODE_LSB = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    output logic               out_valid,
    output logic [SLOT_W-1:0]  out_pos,
    output logic               out_last,
    output logic               out_duplex,
    output logic [COUNT_W-1:0] out_count,
    output logic               out_loop0,
    output logic               out_loop1,
    output logic               out_illegal
);

    logic              w_closes, w_paired, w_mark;
    logic [SLOT_W-1:0] pos;
    logic              close, overrun;
    logic              loop0, loop1;

    grp_code_decode #(.WORD_W(WORD_W), .CODE_LSB(CODE_LSB)) u_dec (
        .word_i   (in_word),
        .closes_o (w_closes),
        .paired_o (w_paired),
        .mark_o   (w_mark)
    );

    slot_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (in_valid),
        .closes_i  (w_closes),
        .pos_o     (pos),
        .close_o   (close),
        .overrun_o (overrun)
    );

    loop_mark_track u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (in_valid),
        .pos_i   (pos),
        .mark_i  (w_mark),
        .end_i   (close | overrun),
        .loop0_o (loop0),
        .loop1_o (loop1)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_pos     <= '0;
            out_last    <= 1'b0;
            out_duplex  <= 1'b0;
            out_count   <= '0;
            out_loop0   <= 1'b0;
            out_loop1   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_pos     <= in_valid ? pos : '0;
            out_last    <= close;
            out_duplex  <= in_valid & w_paired;
            out_count   <= close ? COUNT_W'(pos) + COUNT_W'(1) : '0;
            out_loop0   <= close & loop0;
            out_loop1   <= close & loop1;
            out_illegal <= overrun;
        end
    end

    p_dup_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_duplex |-> out_last);
    p_count_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (out_count != '0 && out_count == COUNT_W'(out_pos) + COUNT_W'(1)));
    p_flags_only_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_loop0 || out_loop1) |-> out_last);
    p_loop1_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_loop1 |-> out_count >= COUNT_W'(3));
    p_err_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_pos == SLOT_W'(MAX_PKT_WORDS - 1) && !out_last && out_count == '0));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_last || out_illegal || out_duplex));

endmodule

// File: tb/sim_pkt_boundary_parser.sv
`timescale 1ns/1ps
module sim_pkt_boundary_parser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid, out_last, out_duplex, out_loop0, out_loop1, out_illegal;
    logic [1:0]  out_pos;
    logic [2:0]  out_count;

    pkt_boundary_parser u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_pos(out_pos), .out_last(out_last),
        .out_duplex(out_duplex), .out_count(out_count), .out_loop0(out_loop0),
        .out_loop1(out_loop1), .out_illegal(out_illegal)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int seq = 0;
    bit done = 0;

    // reference model state
    int pk[$];
    int e_valid, e_pos, e_last, e_dup, e_cnt, e_l0, e_l1, e_ill;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (word %0d)", tag, act, exp, seq);
        end
    endtask

    task automatic compare_all();
        chk("R2 valid", out_valid, e_valid);
        chk("R2 pos", out_pos, e_pos);
        chk("R3 last", out_last, e_last);
        chk("R4 duplex", out_duplex, e_dup);
        chk("R6 count", out_count, e_cnt);
        chk("R7 loop0", out_loop0, e_l0);
        chk("R8 loop1", out_loop1, e_l1);
        chk("R9 illegal", out_illegal, e_ill);
    endtask

    task automatic model_idle();
        e_valid = 0; e_pos = 0; e_last = 0; e_dup = 0;
        e_cnt = 0; e_l0 = 0; e_l1 = 0; e_ill = 0;
    endtask

    task automatic model_word(int code);
        bit closes;
        model_idle();
        pk.push_back(code);
        closes = (code == 3) || (code == 0);
        e_valid = 1;
        e_pos = pk.size() - 1;
        e_dup = (code == 0);
        if (closes) begin
            e_last = 1;
            e_cnt = pk.size();
            e_l0 = (pk.size() >= 2 && pk[0] == 2);
            e_l1 = (pk.size() >= 3 && pk[1] == 2);
            pk.delete();
        end else if (pk.size() == 4) begin
            e_ill = 1;
            pk.delete();
        end
    endtask

    // one cycle: check previous result, then drive next input
    task automatic step(bit v, int code);
        @(negedge clk);
        compare_all();
        in_valid = v;
        if (v) begin
            seq++;
            in_word = {16'h3C5A ^ 16'(seq * 16'h0107), 2'(code), 14'(seq * 14'h0A3)};
            model_word(code);
        end else begin
            in_word = 32'hFFFF_FFFF;
            model_idle();
        end
    endtask

    task automatic packet(int c[$]);
        foreach (c[i]) step(1, c[i]);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        model_idle();
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1 valid in reset", out_valid, 0);
        chk("R1 last in reset", out_last, 0);
        chk("R1 illegal in reset", out_illegal, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first cycle after release
        chk("R1 valid after reset", out_valid, 0);
        chk("R1 count after reset", out_count, 0);
        chk("R1 pos after reset", out_pos, 0);

        packet('{3});                 // R3 single word
        packet('{0});                 // R4 single duplex
        packet('{1, 3});              // R5 two words
        packet('{2, 3});              // R7 loop0
        packet('{1, 2, 3});           // R8 loop1
        packet('{2, 2, 3});           // R7 R8 both
        packet('{2, 2, 1, 3});        // four words, both loops
        packet('{1, 1, 1, 3});        // R6 count 4
        packet('{1, 2, 1, 0});        // R4 duplex closes four-word packet, loop1
        packet('{2, 0});              // duplex closing loop0 packet
        // R10: idle cycles inside a packet
        step(1, 2); step(0, 0); step(0, 0); step(1, 2); step(0, 0); step(1, 3);
        // R9: overrun then resync
        packet('{1, 1, 1, 1});
        packet('{3});
        packet('{2, 2, 2, 2});        // overrun must drop loop flags
        packet('{1, 3});
        packet('{2, 1, 1, 2});        // overrun
        step(0, 0);
        packet('{2, 2, 3});           // markers from overrun packet must not leak
        for (int k = 0; k < 40; k++) step((k % 3) != 2, (k * 7 + 1) % 4);
        step(0, 0);
        step(0, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule